// File: doc/BRIEF.md
# Field Length Meter

This block times incoming video fields for a scan-conversion memory controller. An asynchronous vertical sync input is first brought into the acquisition clock domain through two flip-flops, then looked at only at two strobe instants per line. Each strobe sits at a programmable multiple of four clocks after the rising edge of the horizontal reference. One count unit is the spacing of these strobes, that is, half a line. A sampled low-to-high change of the sync level marks the start of a field. The count reached up to that point becomes the 10-bit measured length, which is presented as a low byte and a 2-bit high part.

Each field start also records which of the two strobes saw the edge, which tells the two interlaced fields apart. It raises a write-pointer reset pulse that lasts one strobe interval and restarts the count. A vertical write window, given in whole lines, opens and closes against that count. Because a new field restarts the count, a field that ends early also closes the window early. In generator mode the sync input is ignored and the block makes its own field starts every programmed number of units. This lets the display side run with no source present.

Top module: `fieldlen_meter`

## Requirements
- R1: After reset, len_lo, len_hi, field_id, wr_rst and vwin_en are all 0.
- R2: A strobe occurs when the clock count since the last rising edge of href equals 4*smp_pos_a (strobe A) or 4*smp_pos_b (strobe B). The synchronized vsync_in is sampled only at these strobes, and A wins if both positions are equal.
- R3: A field start is a strobe at which the sampled vsync is 1 and the previous sample was 0. At each field start the number of strobes since the previous field start is stored as the measured length, with bits 7:0 on len_lo and bits 9:8 on len_hi.
- R4: The running count saturates at 1023, so a field longer than 1023 units reads back as 1023.
- R5: field_id is set to 1 when a field start is detected at strobe B and to 0 when it is detected at strobe A.
- R6: wr_rst goes high at a field start and returns low at the next strobe.
- R7: vwin_en is high while the line index (running count divided by two, 0 at the field start) is at least vwin_start and below vwin_stop.
- R8: A field start before the line index reaches vwin_stop closes the window within two clocks, given vwin_start is nonzero.
- R9: With gen_mode high, vsync_in has no effect. A field start is made at the strobe where the running count reaches gen_len, so the measured length reads gen_len and wr_rst pulses once per gen_len strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| href | input | 1 | Horizontal reference; its rising edge starts each line |
| vsync_in | input | 1 | Asynchronous vertical sync |
| smp_pos_a | input | 8 | Strobe A position, in units of 4 clocks |
| smp_pos_b | input | 8 | Strobe B position, in units of 4 clocks |
| vwin_start | input | 9 | First line of the vertical write window |
| vwin_stop | input | 9 | First line after the vertical write window |
| gen_mode | input | 1 | Free-running field generation, sync ignored |
| gen_len | input | 10 | Field length in units for generator mode |
| len_lo | output | 8 | Measured length, bits 7:0 |
| len_hi | output | 2 | Measured length, bits 9:8 |
| field_id | output | 1 | Strobe (1 = B) that caught the last field start |
| wr_rst | output | 1 | Write-pointer reset pulse |
| vwin_en | output | 1 | Vertical write enable window |

## Verification
Sync edges are placed a whole number of lines apart at a mid-line phase. This gives even lengths, below and above 255, which separate errors in the low byte from errors in the high part. A single edge placed just before line end is caught by the next line's A strobe. That gives an odd length and field_id 0, which tells a wrong strobe choice from a wrong count. Moving strobe B past an edge shows that the programmed position, not a fixed phase, decides the sampling. A 520-line gap checks saturation, and a field cut short inside an open window checks the early close. In generator mode, sync toggling during a counted stretch must leave the length and the reset-pulse rate at the programmed values.

// File: rtl/fl_pkg.sv
package fl_pkg;
    typedef struct packed {
        logic tick;   // a strobe was seen this cycle
        logic rise;   // that strobe caught a new sync level of 1
        logic at_b;   // the strobe was strobe B
    } fl_sample_t;
endpackage

// File: rtl/fl_strobe_gen.sv
module fl_strobe_gen #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             href,
    input  logic [POS_W-1:0] pos_a,
    input  logic [POS_W-1:0] pos_b,
    output logic             stb_a,
    output logic             stb_b
);
    localparam int HCNT_W = POS_W + 2;
    localparam logic [HCNT_W-1:0] HCNT_MAX = '1;

    typedef struct packed {
        logic              href;
        logic [HCNT_W-1:0] hcnt;
        logic              sa;
        logic              sb;
    } st_t;

    st_t  s_d, s_q;
    logic href_rise, moved, hit_a, hit_b;

    always_comb begin
        s_d       = s_q;
        s_d.href  = href;
        href_rise = href & ~s_q.href;
        moved     = 1'b1;
        if (href_rise) begin
            s_d.hcnt = '0;
        end else if (s_q.hcnt != HCNT_MAX) begin
            s_d.hcnt = s_q.hcnt + 1'b1;
        end else begin
            moved = 1'b0;
        end
        hit_a  = moved && (s_d.hcnt == {pos_a, 2'b00});
        hit_b  = moved && (s_d.hcnt == {pos_b, 2'b00}) && !hit_a;
        s_d.sa = hit_a;
        s_d.sb = hit_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stb_a = s_q.sa;
    assign stb_b = s_q.sb;

    // R2: a strobe is a single-cycle event per position
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sa |=> !s_q.sa) else $error("strobe A lasted two cycles");
    assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb_a, stb_b})) else $error("both strobes at once");
endmodule

// File: rtl/fl_vs_sampler.sv
module fl_vs_sampler
    import fl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vs_async,
    input  logic       stb_a,
    input  logic       stb_b,
    input  logic       gen_mode,
    output fl_sample_t smp
);
    typedef struct packed {
        logic       s1;
        logic       s2;
        logic       level;
        fl_sample_t out;
    } st_t;

    st_t  s_d, s_q;
    logic stb;

    always_comb begin
        s_d      = s_q;
        s_d.s1   = vs_async;
        s_d.s2   = s_q.s1;
        stb      = stb_a | stb_b;
        s_d.out.tick = stb;
        s_d.out.at_b = stb_b;
        s_d.out.rise = stb && s_q.s2 && !s_q.level && !gen_mode;
        if (stb) s_d.level = s_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign smp = s_q.out;

    // R2: an edge is only ever reported together with a strobe
    assert_rise_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp.rise |-> smp.tick) else $error("edge without strobe");
    // R9: generator mode suppresses sync edges
    assert_gen_blocks_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gen_mode) |-> !smp.rise) else $error("sync edge in generator mode");
endmodule

// File: rtl/fl_field_cnt.sv
module fl_field_cnt
    import fl_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fl_sample_t       smp,
    input  logic             gen_mode,
    input  logic [LEN_W-1:0] gen_len,
    output logic [LEN_W-1:0] result,
    output logic [LEN_W-1:0] cnt,
    output logic             fid,
    output logic             wrst,
    output logic             fstart
);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;
    localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] res;
        logic             fid;
        logic             wrst;
        logic             fstart;
    } st_t;

    st_t  s_d, s_q;
    logic ev;

    always_comb begin
        s_d        = s_q;
        ev         = smp.tick && (gen_mode ? (s_q.cnt >= gen_len) : smp.rise);
        s_d.fstart = ev;
        if (smp.tick) begin
            if (ev) begin
                s_d.res  = s_q.cnt;
                s_d.cnt  = CNT_ONE;
                s_d.fid  = smp.at_b;
                s_d.wrst = 1'b1;
            end else begin
                s_d.cnt  = (s_q.cnt == CNT_MAX) ? CNT_MAX : s_q.cnt + 1'b1;
                s_d.wrst = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign result = s_q.res;
    assign cnt    = s_q.cnt;
    assign fid    = s_q.fid;
    assign wrst   = s_q.wrst;
    assign fstart = s_q.fstart;

    // R3: the count restarts at every field start
    assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fstart |-> (cnt == CNT_ONE)) else $error("count did not restart");
    // R3: the stored length only changes at a field start
    assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fstart |-> $stable(result)) else $error("length changed between fields");
    // R4: a saturated count stays saturated until the next field start
    assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !ev) |=> (cnt == CNT_MAX)) else $error("count wrapped");
    // R6: the reset pulse clears at the next strobe without a field start
    assert_wrst_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp.tick && !ev) |=> !wrst) else $error("reset pulse too long");
endmodule

// File: rtl/fl_vwindow.sv
module fl_vwindow #(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] start,
    input  logic [LINE_W-1:0] stop,
    output logic              vwe
);
    typedef struct packed {
        logic vwe;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vwe = (line >= start) && (line < stop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vwe = s_q.vwe;

    // R7: an open window implies the bounds were ordered on the previous cycle
    assert_window_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vwe |-> ($past(start) < $past(stop))) else $error("window open with start >= stop");
endmodule

// File: rtl/fieldlen_meter.sv
module fieldlen_meter
    import fl_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             href,
    input  logic             vsync_in,
    input  logic [POS_W-1:0] smp_pos_a,
    input  logic [POS_W-1:0] smp_pos_b,
    input  logic [LEN_W-2:0] vwin_start,
    input  logic [LEN_W-2:0] vwin_stop,
    input  logic             gen_mode,
    input  logic [LEN_W-1:0] gen_len,
    output logic [7:0]       len_lo,
    output logic [LEN_W-9:0] len_hi,
    output logic             field_id,
    output logic             wr_rst,
    output logic             vwin_en
);
    localparam int LINE_W = LEN_W - 1;

    logic             stb_a, stb_b;
    fl_sample_t       smp;
    logic [LEN_W-1:0] result, cnt;
    logic             fstart;

    fl_strobe_gen #(.POS_W(POS_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .href(href),
        .pos_a(smp_pos_a), .pos_b(smp_pos_b),
        .stb_a(stb_a), .stb_b(stb_b)
    );

    fl_vs_sampler u_sampler (
        .clk(clk), .rst_n(rst_n), .vs_async(vsync_in),
        .stb_a(stb_a), .stb_b(stb_b), .gen_mode(gen_mode), .smp(smp)
    );

    fl_field_cnt #(.LEN_W(LEN_W)) u_count (
        .clk(clk), .rst_n(rst_n), .smp(smp),
        .gen_mode(gen_mode), .gen_len(gen_len),
        .result(result), .cnt(cnt), .fid(field_id),
        .wrst(wr_rst), .fstart(fstart)
    );

    fl_vwindow #(.LINE_W(LINE_W)) u_window (
        .clk(clk), .rst_n(rst_n), .line(cnt[LEN_W-1:1]),
        .start(vwin_start), .stop(vwin_stop), .vwe(vwin_en)
    );

    assign len_lo = result[7:0];
    assign len_hi = result[LEN_W-1:8];

    // R8: a new field shuts the window one clock after the count restarts
    assert_field_cuts_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fstart && vwin_start != '0) |=> !vwin_en) else $error("window survived field start");
    // R6: the reset pulse only rises together with a field start
    assert_wrst_from_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_rst) |-> fstart) else $error("reset pulse without field start");
endmodule

// File: tb/sim_fieldlen_meter.sv
module sim_fieldlen_meter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       href = 1'b0;
    logic       vsync_in = 1'b0;
    logic [7:0] smp_pos_a = 8'd2;
    logic [7:0] smp_pos_b = 8'd10;
    logic [8:0] vwin_start = 9'd3;
    logic [8:0] vwin_stop = 9'd10;
    logic       gen_mode = 1'b0;
    logic [9:0] gen_len = 10'd40;
    logic [7:0] len_lo;
    logic [1:0] len_hi;
    logic       field_id, wr_rst, vwin_en;

    int errors = 0;
    int checks = 0;
    int bp = 63;
    bit done = 1'b0;

    fieldlen_meter u0 (
        .clk(clk), .rst_n(rst_n), .href(href), .vsync_in(vsync_in),
        .smp_pos_a(smp_pos_a), .smp_pos_b(smp_pos_b),
        .vwin_start(vwin_start), .vwin_stop(vwin_stop),
        .gen_mode(gen_mode), .gen_len(gen_len),
        .len_lo(len_lo), .len_hi(len_hi), .field_id(field_id),
        .wr_rst(wr_rst), .vwin_en(vwin_en)
    );

    always #4 clk = ~clk;

    // line of 64 clocks, href high for the first half
    initial begin
        forever begin
            @(negedge clk);
            bp   = (bp == 63) ? 0 : bp + 1;
            href = (bp < 32);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic at_pos(input int p);
        forever begin
            @(negedge clk);
            #1;
            if (bp == p) break;
        end
    endtask

    task automatic goto(input int dl, input int p);
        repeat (dl) at_pos(0);
        at_pos(p);
    endtask

    task automatic test_reset();
        chk(len_lo == 0 && len_hi == 0, "R1 length", {len_hi, len_lo}, 0);
        chk(!field_id && !wr_rst && !vwin_en, "R1 flags", {field_id, wr_rst, vwin_en}, 0);
    endtask

    task automatic test_measure();
        goto(2, 20); vsync_in = 1'b1;
        goto(2, 20); vsync_in = 1'b0;
        goto(98, 20); vsync_in = 1'b1;
        at_pos(50);
        chk({len_hi, len_lo} == 200, "R3 length 100 lines", {len_hi, len_lo}, 200);
        chk(field_id == 1'b1, "R5 edge at strobe B", field_id, 1);
        chk(wr_rst == 1'b1, "R6 pulse high", wr_rst, 1);
        goto(1, 20);
        chk(wr_rst == 1'b0, "R6 pulse low after next strobe", wr_rst, 0);
        goto(1, 20); vsync_in = 1'b0;
        goto(148, 20); vsync_in = 1'b1;
        at_pos(50);
        chk(len_lo == 8'd44 && len_hi == 2'd1, "R3 length 300 split", {len_hi, len_lo}, 300);
    endtask

    task automatic test_phase();
        goto(1, 20); vsync_in = 1'b0;
        goto(9, 56); vsync_in = 1'b1;
        goto(1, 20);
        chk({len_hi, len_lo} == 21, "R3 odd length", {len_hi, len_lo}, 21);
        chk(field_id == 1'b0, "R5 edge at strobe A", field_id, 0);
        vsync_in  = 1'b0;
        smp_pos_b = 8'd13;
        goto(3, 46); vsync_in = 1'b1;
        at_pos(60);
        chk(field_id == 1'b1, "R2 moved strobe B catches edge", field_id, 1);
        smp_pos_b = 8'd10;
    endtask

    task automatic test_window();
        goto(1, 30); vsync_in = 1'b0;
        goto(1, 20); vsync_in = 1'b1;
        goto(2, 50); vsync_in = 1'b0;
        chk(vwin_en == 1'b0, "R7 before start line", vwin_en, 0);
        goto(1, 20);
        chk(vwin_en == 1'b1, "R7 at start line", vwin_en, 1);
        goto(6, 50);
        chk(vwin_en == 1'b1, "R7 last open line", vwin_en, 1);
        goto(1, 20);
        chk(vwin_en == 1'b0, "R7 at stop line", vwin_en, 0);
    endtask

    task automatic test_cutoff();
        vwin_stop = 9'd200;
        goto(1, 20); vsync_in = 1'b1;
        goto(2, 20); vsync_in = 1'b0;
        goto(38, 20); vsync_in = 1'b1;
        at_pos(30);
        chk(vwin_en == 1'b1, "R8 window open before short field ends", vwin_en, 1);
        at_pos(50);
        chk(vwin_en == 1'b0, "R8 window cut by new field", vwin_en, 0);
        chk({len_hi, len_lo} == 80, "R3 short field length", {len_hi, len_lo}, 80);
    endtask

    task automatic test_saturate();
        goto(2, 20); vsync_in = 1'b0;
        goto(520, 20); vsync_in = 1'b1;
        at_pos(50);
        chk(len_lo == 8'hff && len_hi == 2'd3, "R4 saturated length", {len_hi, len_lo}, 1023);
    endtask

    task automatic test_generator();
        int rises = 0;
        logic prev;
        gen_mode = 1'b1;
        gen_len  = 10'd40;
        goto(2, 20); vsync_in = 1'b0;
        goto(45, 20);
        chk({len_hi, len_lo} == 40, "R9 generated length", {len_hi, len_lo}, 40);
        prev = wr_rst;
        for (int i = 0; i < 60 * 64; i++) begin
            @(negedge clk);
            #1;
            if ((i % 448) == 100) vsync_in = 1'b1;
            if ((i % 448) == 300) vsync_in = 1'b0;
            if (wr_rst && !prev) rises++;
            prev = wr_rst;
        end
        chk(rises == 3, "R9 pulses follow gen_len, sync ignored", rises, 3);
        chk({len_hi, len_lo} == 40, "R9 length unchanged by sync", {len_hi, len_lo}, 40);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        #1;
        test_reset();
        rst_n = 1'b1;
        test_measure();
        test_phase();
        test_window();
        test_cutoff();
        test_saturate();
        test_generator();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule